// File: doc/BRIEF.md
# Pipeline Execute Unit with Fixed-Latency Multiply and Divide

This block is the third stage of a five-stage in-order integer pipeline. Each accepted operation carries an operation code, two 32-bit register operands, the program counter and an immediate. Single-cycle arithmetic, logic, shift and compare operations produce a registered result on the clock edge that accepts them. Branch conditions and jump targets are resolved here, and the redirect reaches fetch after that same edge.

Multiply and divide operations have fixed latencies set by parameters (3 and 5 cycles by default). A small sequencer holds the stage busy while one of them is in flight. During that time the pipeline stalls, and any operation offered is refused. Memory-access control bits, including the instruction-fence request, travel through the stage unchanged and arrive one cycle later. A build-time switch removes the multiply/divide hardware. In that build a multiply or divide request is reported as illegal.

Top module: `exec_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `busy_o`, `res_valid_o`, `br_taken_o`, `div_zero_o`, `illegal_o` and `mem_ctl_o` are all zero.
- R2: Single-cycle codes are: 0 add, 1 subtract, 2 shift left, 3 logical shift right, 4 arithmetic shift right, 5 and, 6 or, 7 xor, 8 signed less-than, 9 unsigned less-than. Shifts use `opb_i[4:0]` and compares give 1 or 0. The result appears with `res_valid_o` high after the accepting edge.
- R3: Conditional branch codes are: 10 equal, 11 not equal, 12 signed less, 13 signed greater-or-equal, 14 unsigned less, 15 unsigned greater-or-equal. They compare `opa_i` with `opb_i`. After the accepting edge, `br_taken_o` gives the decision and `br_target_o` = `pc_i`+`imm_i`. `res_valid_o` stays low.
- R4: Code 16 (jump) and code 17 (register jump) always give `br_taken_o` high, with result `pc_i`+4 and `res_valid_o` high. The target is `pc_i`+`imm_i` for code 16 and (`opa_i`+`imm_i`) with bit 0 cleared for code 17.
- R5: Multiply codes are: 18 low word, 19 high word signed×signed, 20 high word signed×unsigned, 21 high word unsigned×unsigned. `busy_o` is high for MUL_CYCLES-1 cycles, and the result appears with `res_valid_o` on the MUL_CYCLES-th edge counted from acceptance.
- R6: Divide codes are: 22 signed quotient, 23 unsigned quotient, 24 signed remainder, 25 unsigned remainder. Their timing matches R5 with DIV_CYCLES, and results round toward zero.
- R7: A divide with `opb_i` = 0 gives all ones for the quotient and the dividend for the remainder, and raises `div_zero_o` together with `res_valid_o`.
- R8: A signed divide of 0x80000000 by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0, and `div_zero_o` stays low.
- R9: While `busy_o` is high, `in_valid_i` is ignored. No extra result, branch or memory-control output arises from it.
- R10: `mem_ctl_o` equals the `mem_ctl_i` of an accepted operation one cycle after acceptance, and is zero in any cycle that follows no acceptance.
- R11: Codes 26 to 31, and codes 18 to 25 when HAS_M = 0, raise `illegal_o` after the accepting edge. In that case `res_valid_o` and `busy_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation offered this cycle |
| op_i | input | 5 | Operation code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| pc_i | input | 32 | Program counter of the operation |
| imm_i | input | 32 | Immediate |
| mem_ctl_i | input | MEMW | Memory-stage control bits to pass through |
| res_o | output | 32 | Result |
| res_valid_o | output | 1 | Result valid pulse |
| br_taken_o | output | 1 | Redirect fetch |
| br_target_o | output | 32 | Redirect address |
| busy_o | output | 1 | Stall: multi-cycle operation in flight |
| div_zero_o | output | 1 | Divide by zero reported with result |
| illegal_o | output | 1 | Unsupported operation |
| mem_ctl_o | output | MEMW | Memory-stage control bits, one cycle later |

## Verification
A wrong sequencer count makes `busy_o` fall one or more cycles early or late, and the result pulse moves with it. The bench sees this at the first multiply or divide, because it checks the busy and result outputs on every cycle of the window. A sequencer stuck busy stops every later result from appearing, so the next check reports it. A stale or wrong latched operand shows up as a wrong result value in the same cycle as the result pulse. A leak of the refused stall traffic shows up within one cycle as a nonzero `mem_ctl_o`.

// File: rtl/exec_pkg.sv
package exec_pkg;
    localparam int XLEN = 32;
    localparam int OPW  = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 5'd0,  OP_SUB = 5'd1,  OP_SLL = 5'd2,  OP_SRL = 5'd3,
        OP_SRA = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
        OP_SLT = 5'd8,  OP_SLTU = 5'd9,
        OP_BEQ = 5'd10, OP_BNE = 5'd11, OP_BLT = 5'd12, OP_BGE = 5'd13,
        OP_BLTU = 5'd14, OP_BGEU = 5'd15,
        OP_JMP = 5'd16, OP_JMPR = 5'd17,
        OP_MUL = 5'd18, OP_MULH = 5'd19, OP_MULHSU = 5'd20, OP_MULHU = 5'd21,
        OP_DIV = 5'd22, OP_DIVU = 5'd23, OP_REM = 5'd24, OP_REMU = 5'd25
    } ex_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_MUL  = 2'd1,
        SQ_DIV  = 2'd2
    } seq_state_e;

    function automatic logic op_is_mul(input logic [OPW-1:0] op);
        return (op >= OP_MUL) && (op <= OP_MULHU);
    endfunction

    function automatic logic op_is_div(input logic [OPW-1:0] op);
        return (op >= OP_DIV) && (op <= OP_REMU);
    endfunction

    function automatic logic op_is_known(input logic [OPW-1:0] op);
        return op <= OP_REMU;
    endfunction
endpackage

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   pc,
    input  logic [W-1:0]   imm,
    output logic [W-1:0]   res,
    output logic           writes,
    output logic           taken,
    output logic [W-1:0]   target
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] sh;
    logic           eq, lt_s, lt_u;
    logic [W-1:0]   jr_sum;

    assign sh     = b[SHW-1:0];
    assign eq     = (a == b);
    assign lt_s   = ($signed(a) < $signed(b));
    assign lt_u   = (a < b);
    assign jr_sum = a + imm;

    always_comb begin
        res    = '0;
        writes = 1'b1;
        taken  = 1'b0;
        target = pc + imm;
        unique case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_SLL:  res = a << sh;
            OP_SRL:  res = a >> sh;
            OP_SRA:  res = W'($signed(a) >>> sh);
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SLT:  res = {{(W-1){1'b0}}, lt_s};
            OP_SLTU: res = {{(W-1){1'b0}}, lt_u};
            OP_BEQ:  begin writes = 1'b0; taken = eq;    end
            OP_BNE:  begin writes = 1'b0; taken = !eq;   end
            OP_BLT:  begin writes = 1'b0; taken = lt_s;  end
            OP_BGE:  begin writes = 1'b0; taken = !lt_s; end
            OP_BLTU: begin writes = 1'b0; taken = lt_u;  end
            OP_BGEU: begin writes = 1'b0; taken = !lt_u; end
            OP_JMP:  begin res = pc + W'(4); taken = 1'b1; end
            OP_JMPR: begin
                res    = pc + W'(4);
                taken  = 1'b1;
                target = {jr_sum[W-1:1], 1'b0};
            end
            default: writes = 1'b0;
        endcase
    end
endmodule

// File: rtl/exec_muldiv.sv
module exec_muldiv
    import exec_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           dz
);
    localparam int PW = 2 * W + 2;

    logic                 sgn_a, sgn_b;
    logic signed [W:0]    xa, xb;
    logic signed [PW-1:0] prod;
    logic                 b_zero, ovf;
    logic [W-1:0]         q_s, q_u, r_s, r_u;
    logic [W-1:0]         most_neg;

    assign most_neg = {1'b1, {(W-1){1'b0}}};
    assign sgn_a = (op == OP_MULH) || (op == OP_MULHSU);
    assign sgn_b = (op == OP_MULH);
    assign xa    = {sgn_a & a[W-1], a};
    assign xb    = {sgn_b & b[W-1], b};
    assign prod  = PW'(xa) * PW'(xb);

    assign b_zero = (b == '0);
    assign ovf    = (a == most_neg) && (b == '1);

    always_comb begin
        q_s = '0;
        r_s = '0;
        q_u = '0;
        r_u = '0;
        if (!b_zero) begin
            q_u = a / b;
            r_u = a % b;
            if (!ovf) begin
                q_s = W'($signed(a) / $signed(b));
                r_s = W'($signed(a) % $signed(b));
            end
        end
    end

    always_comb begin
        res = '0;
        dz  = 1'b0;
        if (op_is_div(op) && b_zero) begin
            dz  = 1'b1;
            res = ((op == OP_DIV) || (op == OP_DIVU)) ? '1 : a;
        end else begin
            unique case (op)
                OP_MUL:    res = prod[W-1:0];
                OP_MULH,
                OP_MULHSU,
                OP_MULHU:  res = prod[2*W-1:W];
                OP_DIV:    res = ovf ? most_neg : q_s;
                OP_DIVU:   res = q_u;
                OP_REM:    res = ovf ? '0 : r_s;
                OP_REMU:   res = r_u;
                default:   res = '0;
            endcase
        end
    end
endmodule

// File: rtl/exec_seq.sv
module exec_seq
    import exec_pkg::*;
#(
    parameter int MUL_CYCLES = 3,
    parameter int DIV_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_mul,
    input  logic start_div,
    output logic busy,
    output logic done
);
    localparam int MAXL = (MUL_CYCLES > DIV_CYCLES) ? MUL_CYCLES : DIV_CYCLES;
    localparam int CW   = (MAXL > 2) ? $clog2(MAXL) : 1;

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (start_mul) begin
                    s_d.st  = SQ_MUL;
                    s_d.cnt = CW'(MUL_CYCLES - 2);
                end else if (start_div) begin
                    s_d.st  = SQ_DIV;
                    s_d.cnt = CW'(DIV_CYCLES - 2);
                end
            end
            SQ_MUL, SQ_DIV: begin
                if (s_q.cnt == '0) begin
                    done   = 1'b1;
                    s_d.st = SQ_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - CW'(1);
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign busy = (s_q.st != SQ_IDLE);
endmodule

// File: rtl/exec_unit.sv
module exec_unit
    import exec_pkg::*;
#(
    parameter int HAS_M      = 1,
    parameter int MUL_CYCLES = 3,
    parameter int DIV_CYCLES = 5,
    parameter int MEMW       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid_i,
    input  logic [4:0]      op_i,
    input  logic [31:0]     opa_i,
    input  logic [31:0]     opb_i,
    input  logic [31:0]     pc_i,
    input  logic [31:0]     imm_i,
    input  logic [MEMW-1:0] mem_ctl_i,
    output logic [31:0]     res_o,
    output logic            res_valid_o,
    output logic            br_taken_o,
    output logic [31:0]     br_target_o,
    output logic            busy_o,
    output logic            div_zero_o,
    output logic            illegal_o,
    output logic [MEMW-1:0] mem_ctl_o
);
    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            vld;
        logic            taken;
        logic [XLEN-1:0] target;
        logic            dz;
        logic            ill;
        logic [MEMW-1:0] mem;
        logic [OPW-1:0]  md_op;
        logic [XLEN-1:0] md_a;
        logic [XLEN-1:0] md_b;
    } ex_t;

    ex_t r_d, r_q;

    logic            accept, is_md, busy, done;
    logic [XLEN-1:0] alu_res, alu_tgt, md_res;
    logic            alu_wr, alu_taken, md_dz;

    assign accept = in_valid_i && !busy;
    assign is_md  = op_is_mul(op_i) || op_is_div(op_i);

    exec_alu #(.W(XLEN)) i_alu (
        .op(op_i), .a(opa_i), .b(opb_i), .pc(pc_i), .imm(imm_i),
        .res(alu_res), .writes(alu_wr), .taken(alu_taken), .target(alu_tgt)
    );

    generate
        if (HAS_M != 0) begin : g_md
            exec_muldiv #(.W(XLEN)) i_md (
                .op(r_q.md_op), .a(r_q.md_a), .b(r_q.md_b),
                .res(md_res), .dz(md_dz)
            );
            exec_seq #(.MUL_CYCLES(MUL_CYCLES), .DIV_CYCLES(DIV_CYCLES)) i_seq (
                .clk(clk), .rst_n(rst_n),
                .start_mul(accept && op_is_mul(op_i)),
                .start_div(accept && op_is_div(op_i)),
                .busy(busy), .done(done)
            );
        end else begin : g_no_md
            assign md_res = '0;
            assign md_dz  = 1'b0;
            assign busy   = 1'b0;
            assign done   = 1'b0;
        end
    endgenerate

    always_comb begin
        r_d        = r_q;
        r_d.res    = '0;
        r_d.vld    = 1'b0;
        r_d.taken  = 1'b0;
        r_d.target = '0;
        r_d.dz     = 1'b0;
        r_d.ill    = 1'b0;
        r_d.mem    = accept ? mem_ctl_i : '0;
        if (done) begin
            r_d.res = md_res;
            r_d.vld = 1'b1;
            r_d.dz  = md_dz;
        end else if (accept) begin
            if (is_md) begin
                if (HAS_M != 0) begin
                    r_d.md_op = op_i;
                    r_d.md_a  = opa_i;
                    r_d.md_b  = opb_i;
                end else begin
                    r_d.ill = 1'b1;
                end
            end else if (!op_is_known(op_i)) begin
                r_d.ill = 1'b1;
            end else begin
                r_d.res    = alu_res;
                r_d.vld    = alu_wr;
                r_d.taken  = alu_taken;
                r_d.target = alu_tgt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign res_o       = r_q.res;
    assign res_valid_o = r_q.vld;
    assign br_taken_o  = r_q.taken;
    assign br_target_o = r_q.target;
    assign div_zero_o  = r_q.dz;
    assign illegal_o   = r_q.ill;
    assign mem_ctl_o   = r_q.mem;
    assign busy_o      = busy;
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk
    import exec_pkg::*;
#(
    parameter int HAS_M      = 1,
    parameter int MUL_CYCLES = 3,
    parameter int DIV_CYCLES = 5,
    parameter int MEMW       = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid_i,
    input logic [4:0]      op_i,
    input logic [MEMW-1:0] mem_ctl_i,
    input logic            res_valid_o,
    input logic            busy_o,
    input logic            div_zero_o,
    input logic            illegal_o,
    input logic [MEMW-1:0] mem_ctl_o
);
    localparam int MAXL = (MUL_CYCLES > DIV_CYCLES) ? MUL_CYCLES : DIV_CYCLES;

    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= 0;
        else if (busy_o) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    // R6 / R5: no busy run exceeds the longest latency minus one
    assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= MAXL - 1);

    assert_release_gives_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> res_valid_o);

    assert_busy_refuses_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && in_valid_i) |=> (mem_ctl_o == '0));

    assert_mem_forward_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !busy_o) |=> (mem_ctl_o == $past(mem_ctl_i)));

    assert_dz_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> res_valid_o);

    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!res_valid_o && !busy_o));

    assert_alu_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !busy_o && (op_i <= OP_SLTU)) |=> (res_valid_o && !busy_o));
endmodule

bind exec_unit exec_unit_chk #(
    .HAS_M(HAS_M), .MUL_CYCLES(MUL_CYCLES), .DIV_CYCLES(DIV_CYCLES), .MEMW(MEMW)
) i_exec_unit_chk (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_i(op_i),
    .mem_ctl_i(mem_ctl_i), .res_valid_o(res_valid_o), .busy_o(busy_o),
    .div_zero_o(div_zero_o), .illegal_o(illegal_o), .mem_ctl_o(mem_ctl_o)
);

// File: tb/test_exec_unit.sv
`timescale 1ns/1ps
module test_exec_unit;
    localparam int MULC = 3;
    localparam int DIVC = 5;
    localparam int MW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [4:0]    op = '0;
    logic [31:0]   a = '0, b = '0, pc = '0, imm = '0;
    logic [MW-1:0] mem = '0;

    logic [31:0]   res, tgt, n_res, n_tgt;
    logic          vld, tkn, busy, dz, ill, n_vld, n_tkn, n_busy, n_dz, n_ill;
    logic [MW-1:0] mem_o, n_mem_o;

    int checks = 0;
    int errs   = 0;

    always #5 clk = ~clk;

    exec_unit #(.HAS_M(1), .MUL_CYCLES(MULC), .DIV_CYCLES(DIVC), .MEMW(MW)) i_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .op_i(op), .opa_i(a), .opb_i(b),
        .pc_i(pc), .imm_i(imm), .mem_ctl_i(mem), .res_o(res), .res_valid_o(vld),
        .br_taken_o(tkn), .br_target_o(tgt), .busy_o(busy), .div_zero_o(dz),
        .illegal_o(ill), .mem_ctl_o(mem_o)
    );

    exec_unit #(.HAS_M(0), .MUL_CYCLES(MULC), .DIV_CYCLES(DIVC), .MEMW(MW)) i_exec_unit_nom (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .op_i(op), .opa_i(a), .opb_i(b),
        .pc_i(pc), .imm_i(imm), .mem_ctl_i(mem), .res_o(n_res), .res_valid_o(n_vld),
        .br_taken_o(n_tkn), .br_target_o(n_tgt), .busy_o(n_busy), .div_zero_o(n_dz),
        .illegal_o(n_ill), .mem_ctl_o(n_mem_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] res;
        logic        vld;
        logic        tkn;
        logic [31:0] tgt;
        logic        dz;
        logic        ill;
    } exp_t;

    function automatic exp_t model(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                                   input logic [31:0] p, input logic [31:0] im);
        exp_t e;
        int sx, sy;
        longint sl;
        logic [63:0] ul;
        sx = int'(x);
        sy = int'(y);
        e = '0;
        if (o <= 5'd9) e.vld = 1'b1;
        case (o)
            5'd0: e.res = x + y;
            5'd1: e.res = x - y;
            5'd2: e.res = x << y[4:0];
            5'd3: e.res = x >> y[4:0];
            5'd4: e.res = 32'(sx >>> y[4:0]);
            5'd5: e.res = x & y;
            5'd6: e.res = x | y;
            5'd7: e.res = x ^ y;
            5'd8: e.res = (sx < sy) ? 32'd1 : 32'd0;
            5'd9: e.res = (x < y) ? 32'd1 : 32'd0;
            5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15: begin
                e.tgt = p + im;
                case (o)
                    5'd10: e.tkn = (x == y);
                    5'd11: e.tkn = (x != y);
                    5'd12: e.tkn = (sx < sy);
                    5'd13: e.tkn = (sx >= sy);
                    5'd14: e.tkn = (x < y);
                    default: e.tkn = (x >= y);
                endcase
            end
            5'd16, 5'd17: begin
                e.vld = 1'b1; e.tkn = 1'b1; e.res = p + 32'd4;
                e.tgt = (o == 5'd16) ? p + im : ((x + im) & 32'hFFFF_FFFE);
            end
            5'd18, 5'd19, 5'd20, 5'd21: begin
                e.vld = 1'b1;
                if (o == 5'd21) begin
                    ul = {32'd0, x} * {32'd0, y};
                    e.res = ul[63:32];
                end else if (o == 5'd20) begin
                    sl = longint'(sx) * longint'({32'd0, y});
                    e.res = 32'(sl >>> 32);
                end else begin
                    sl = longint'(sx) * longint'(sy);
                    e.res = (o == 5'd18) ? 32'(sl) : 32'(sl >>> 32);
                end
            end
            5'd22, 5'd23, 5'd24, 5'd25: begin
                e.vld = 1'b1;
                if (y == 32'd0) begin
                    e.dz  = 1'b1;
                    e.res = (o == 5'd22 || o == 5'd23) ? 32'hFFFF_FFFF : x;
                end else if ((o == 5'd22 || o == 5'd24) && x == 32'h8000_0000 && y == 32'hFFFF_FFFF) begin
                    e.res = (o == 5'd22) ? x : 32'd0;
                end else begin
                    case (o)
                        5'd22: e.res = 32'(sx / sy);
                        5'd23: e.res = x / y;
                        5'd24: e.res = 32'(sx % sy);
                        default: e.res = x % y;
                    endcase
                end
            end
            default: e.ill = 1'b1;
        endcase
        return e;
    endfunction

    function automatic string tag_of(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y);
        if (o <= 5'd9) return "R2";
        if (o <= 5'd15) return "R3";
        if (o <= 5'd17) return "R4";
        if (o <= 5'd21) return "R5";
        if (o <= 5'd25) begin
            if (y == 0) return "R7";
            if ((o == 5'd22 || o == 5'd24) && x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return "R8";
            return "R6";
        end
        return "R11";
    endfunction

    task automatic check_out(input string tag, input exp_t e);
        checks++;
        if (res !== e.res || vld !== e.vld || tkn !== e.tkn || (e.tkn && tgt !== e.tgt) ||
            dz !== e.dz || ill !== e.ill || busy !== 1'b0) begin
            errs++;
            $display("FAIL %s op=%0d a=%h b=%h: got res=%h v=%b t=%b tg=%h dz=%b il=%b bz=%b expected res=%h v=%b t=%b tg=%h dz=%b il=%b bz=0",
                     tag, op, a, b, res, vld, tkn, tgt, dz, ill, busy, e.res, e.vld, e.tkn, e.tgt, e.dz, e.ill);
        end
    endtask

    task automatic run_op(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                          input logic [31:0] p, input logic [31:0] im, input logic [MW-1:0] m);
        exp_t e;
        int lat;
        string tg;
        e  = model(o, x, y, p, im);
        tg = tag_of(o, x, y);
        lat = (o >= 5'd18 && o <= 5'd21) ? MULC : ((o >= 5'd22 && o <= 5'd25) ? DIVC : 1);
        @(negedge clk);
        op = o; a = x; b = y; pc = p; imm = im; mem = m; in_valid = 1'b1;
        @(negedge clk);
        chk("R10 mem forwarded", 32'(mem_o), 32'(m));
        if (lat > 1) begin
            chk("R11 no-M build flags illegal", {29'd0, n_ill, n_vld, n_busy}, 32'b100);
            // R9: offer other work while busy; it must be refused
            op = 5'd16; a = 32'h55; mem = 8'hA5;
            chk({tg, " busy window"}, {30'd0, busy, vld}, 32'b10);
            for (int i = 1; i < lat; i++) begin
                @(negedge clk);
                chk("R9 refused mem while busy", 32'(mem_o), 32'd0);
                if (i < lat - 1) chk({tg, " busy window"}, {30'd0, busy, vld}, 32'b10);
            end
            chk("R9 no redirect from refused op", {31'd0, tkn}, 32'd0);
        end
        check_out(tg, e);
        in_valid = 1'b0;
    endtask

    logic [31:0] vals [10];

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        vals[0] = 32'd0;          vals[1] = 32'd1;          vals[2] = 32'd2;
        vals[3] = 32'd7;          vals[4] = 32'hFFFF_FFFF;  vals[5] = 32'h8000_0000;
        vals[6] = 32'h7FFF_FFFF;  vals[7] = 32'hFFFF_FFF9;  vals[8] = 32'd31;
        vals[9] = 32'h1234_5678;
        in_valid = 1'b1;
        op = 5'd18; mem = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {25'd0, busy, vld, tkn, dz, ill, |mem_o}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {25'd0, busy, vld, tkn, dz, ill, |mem_o}, 32'd0);
        for (int o = 0; o < 32; o++) begin
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 10; j++) begin
                    run_op(5'(o), vals[i], vals[j], 32'h0000_1000 + 32'(4 * i),
                           vals[j] ^ 32'h0000_0101, 8'(o * 7 + i * 3 + j + 1));
                end
            end
        end
        @(negedge clk);
        chk("R10 idle cycle mem zero", 32'(mem_o), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end
endmodule